// File: doc/BRIEF.md
# Dual-Source Register File

This block is a sixteen-entry register file with one write port and two read ports for a microcoded datapath. On every cycle, each of the three ports (write, read A, read B) takes its register number from one of two places. The first is a 4-bit register field decoded from the current instruction. The second is a 5-bit field carried by the microinstruction, whose top bit picks the source and whose low four bits are a register number of its own. The microprogram can therefore either use the registers named by the instruction or reach any of the sixteen registers directly, for example to hold temporaries.

Register 0 has no storage behind it. Both read ports return zero for it, and any write aimed at it is dropped. The other fifteen registers are flops that clear on a synchronous active-high reset. The word width is a parameter and defaults to 16 bits.

Reads are combinational from the selected register. Writes land on the rising clock edge, so a read of the register being written in the same cycle still shows the old contents.

Top module: `dsrf_regfile`

## Requirements
- R1: The file holds 2**ADDR_W registers (16 by default), each DATA_W bits wide (16 by default). Every register number is ADDR_W bits.
- R2: Each port has a microinstruction field of ADDR_W+1 bits. When the top bit of that field is 1, the port uses the field's low ADDR_W bits as its register number. When the top bit is 0, the port uses its instruction-derived address input. The write port and both read ports each make this choice on their own in every cycle.
- R3: When wr_en is 1 at a rising clock edge, the selected destination register (other than register 0) takes wr_data.
- R4: When wr_en is 0 at a rising clock edge, no register changes.
- R5: A read of register 0 on either read port returns all zeros.
- R6: A write to register 0 is discarded and changes no register.
- R7: Read data follows the selected register combinationally. A read of the register being written in the same cycle returns the value it held before the edge, and the new value from the next cycle on.
- R8: A synchronous active-high reset clears registers 1 to 15 to zero.
- R9: The two read ports are independent. They may select any pair of registers, including the same one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| ir_wr_addr | input | ADDR_W | Destination register number taken from the instruction |
| ir_rda_addr | input | ADDR_W | Read A register number taken from the instruction |
| ir_rdb_addr | input | ADDR_W | Read B register number taken from the instruction |
| uc_wr_field | input | ADDR_W+1 | Microinstruction destination field: top bit selects source, low bits are a register number |
| uc_rda_field | input | ADDR_W+1 | Microinstruction read A field, same layout |
| uc_rdb_field | input | ADDR_W+1 | Microinstruction read B field, same layout |
| wr_en | input | 1 | Write enable |
| wr_data | input | DATA_W | Data to write |
| rda_data | output | DATA_W | Read A data |
| rdb_data | output | DATA_W | Read B data |

## Verification
The bound checker tests, on every cycle, that a selected register 0 reads as zero on both ports. It also checks that a register written in the previous cycle reads back the written word, that a register with no write and an unchanged selection holds its value, and that everything reads zero right after reset. Other behaviours can only be shown by the bench's directed scenarios. These are: that the source bit really routes the alternate field, tested with a decoy value on the unselected input; that a write to register 0 leaves every other register untouched; that a low enable blocks the write; and that a same-cycle read returns the old word.

// File: rtl/dsrf_pkg.sv
package dsrf_pkg;

  typedef enum logic {
    SRC_INSTR = 1'b0,
    SRC_MICRO = 1'b1
  } addr_src_e;

  localparam int PORT_WR  = 0;
  localparam int PORT_RDA = 1;
  localparam int PORT_RDB = 2;
  localparam int NPORTS   = 3;

endpackage

// File: rtl/dsrf_addr_sel.sv
module dsrf_addr_sel
  import dsrf_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] instr_addr,
  input  logic [ADDR_W:0]   micro_field,
  output logic [ADDR_W-1:0] sel_addr
);

  addr_src_e src;

  // R2: top bit of the microinstruction field picks the address source
  assign src = addr_src_e'(micro_field[ADDR_W]);

  always_comb begin
    if (src == SRC_MICRO) sel_addr = micro_field[ADDR_W-1:0];
    else                  sel_addr = instr_addr;
  end

endmodule

// File: rtl/dsrf_store.sv
module dsrf_store #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4,
  localparam int NREGS = 1 << ADDR_W
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             wr_addr,
  input  logic [DATA_W-1:0]             wr_data,
  output logic [NREGS-1:0][DATA_W-1:0]  contents
);

  for (genvar i = 0; i < NREGS; i++) begin : g_reg
    if (i == 0) begin : g_zero
      // R5, R6: entry 0 has no storage element
      assign contents[i] = '0;
    end else begin : g_flop
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk) begin
        if (rst)                                    q <= '0;      // R8
        else if (wr_en && wr_addr == ADDR_W'(i))    q <= wr_data; // R3, R4
      end
      assign contents[i] = q;
    end
  end

endmodule

// File: rtl/dsrf_rd_port.sv
module dsrf_rd_port #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4,
  localparam int NREGS = 1 << ADDR_W
) (
  input  logic [NREGS-1:0][DATA_W-1:0] contents,
  input  logic [ADDR_W-1:0]            rd_addr,
  output logic [DATA_W-1:0]            rd_data
);

  // R7: combinational read; R5: register 0 forced to zero
  always_comb begin
    if (rd_addr == '0) rd_data = '0;
    else               rd_data = contents[rd_addr];
  end

endmodule

// File: rtl/dsrf_regfile.sv
module dsrf_regfile
  import dsrf_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] ir_wr_addr,
  input  logic [ADDR_W-1:0] ir_rda_addr,
  input  logic [ADDR_W-1:0] ir_rdb_addr,
  input  logic [ADDR_W:0]   uc_wr_field,
  input  logic [ADDR_W:0]   uc_rda_field,
  input  logic [ADDR_W:0]   uc_rdb_field,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rda_data,
  output logic [DATA_W-1:0] rdb_data
);

  localparam int NREGS   = 1 << ADDR_W;
  localparam int FIELD_W = ADDR_W + 1;

  logic [NPORTS-1:0][ADDR_W-1:0]  ir_addr;
  logic [NPORTS-1:0][FIELD_W-1:0] uc_field;
  logic [NPORTS-1:0][ADDR_W-1:0]  sel_addr;
  logic [NREGS-1:0][DATA_W-1:0]   contents;
  logic [1:0][DATA_W-1:0]         rd_bus;

  logic [ADDR_W-1:0] wr_sel;
  logic [ADDR_W-1:0] rda_sel;
  logic [ADDR_W-1:0] rdb_sel;

  assign ir_addr[PORT_WR]   = ir_wr_addr;
  assign ir_addr[PORT_RDA]  = ir_rda_addr;
  assign ir_addr[PORT_RDB]  = ir_rdb_addr;
  assign uc_field[PORT_WR]  = uc_wr_field;
  assign uc_field[PORT_RDA] = uc_rda_field;
  assign uc_field[PORT_RDB] = uc_rdb_field;

  // R2: one independent source selector per port
  for (genvar p = 0; p < NPORTS; p++) begin : g_sel
    dsrf_addr_sel #(.ADDR_W(ADDR_W)) u_sel (
      .instr_addr  (ir_addr[p]),
      .micro_field (uc_field[p]),
      .sel_addr    (sel_addr[p])
    );
  end

  assign wr_sel  = sel_addr[PORT_WR];
  assign rda_sel = sel_addr[PORT_RDA];
  assign rdb_sel = sel_addr[PORT_RDB];

  dsrf_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_addr  (wr_sel),
    .wr_data  (wr_data),
    .contents (contents)
  );

  // R9: two independent read ports
  for (genvar r = 0; r < 2; r++) begin : g_rd
    dsrf_rd_port #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
      .contents (contents),
      .rd_addr  (sel_addr[PORT_RDA + r]),
      .rd_data  (rd_bus[r])
    );
  end

  assign rda_data = rd_bus[0];
  assign rdb_data = rd_bus[1];

endmodule

// File: rtl/dsrf_checker.sv
module dsrf_checker #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic [ADDR_W-1:0] wr_sel,
  input logic [ADDR_W-1:0] rda_sel,
  input logic [ADDR_W-1:0] rdb_sel,
  input logic [DATA_W-1:0] rda_data,
  input logic [DATA_W-1:0] rdb_data
);

  AST_ZERO_READ_A: assert property (@(posedge clk) disable iff (rst)
    rda_sel == '0 |-> rda_data == '0); // R5
  AST_ZERO_READ_B: assert property (@(posedge clk) disable iff (rst)
    rdb_sel == '0 |-> rdb_data == '0); // R5

  AST_WRITE_LANDS_A: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_en) && $past(wr_sel) != '0 && rda_sel == $past(wr_sel))
      |-> rda_data == $past(wr_data)); // R3
  AST_WRITE_LANDS_B: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_en) && $past(wr_sel) != '0 && rdb_sel == $past(wr_sel))
      |-> rdb_data == $past(wr_data)); // R3

  AST_HOLD_A: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && rda_sel == $past(rda_sel) && !($past(wr_en) && $past(wr_sel) == rda_sel))
      |-> rda_data == $past(rda_data)); // R4
  AST_HOLD_B: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && rdb_sel == $past(rdb_sel) && !($past(wr_en) && $past(wr_sel) == rdb_sel))
      |-> rdb_data == $past(rdb_data)); // R4

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (rda_data == '0 && rdb_data == '0)); // R8

endmodule

bind dsrf_regfile dsrf_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .wr_en    (wr_en),
  .wr_data  (wr_data),
  .wr_sel   (wr_sel),
  .rda_sel  (rda_sel),
  .rdb_sel  (rdb_sel),
  .rda_data (rda_data),
  .rdb_data (rdb_data)
);

// File: tb/dsrf_regfile_test.sv
`timescale 1ns/1ps
module dsrf_regfile_test;

  localparam int DW = 16;
  localparam int AW = 4;
  localparam int NR = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] ir_wr_addr = '0, ir_rda_addr = '0, ir_rdb_addr = '0;
  logic [AW:0]   uc_wr_field = '0, uc_rda_field = '0, uc_rdb_field = '0;
  logic          wr_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rda_data, rdb_data;

  logic [DW-1:0] model [NR];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dsrf_regfile #(.DATA_W(DW), .ADDR_W(AW)) uut (
    .clk(clk), .rst(rst),
    .ir_wr_addr(ir_wr_addr), .ir_rda_addr(ir_rda_addr), .ir_rdb_addr(ir_rdb_addr),
    .uc_wr_field(uc_wr_field), .uc_rda_field(uc_rda_field), .uc_rdb_field(uc_rdb_field),
    .wr_en(wr_en), .wr_data(wr_data), .rda_data(rda_data), .rdb_data(rdb_data)
  );

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive one port: the unselected input carries a decoy register number.
  task automatic drive(input bit micro, input logic [AW-1:0] a,
                       output logic [AW-1:0] ir, output logic [AW:0] uc);
    if (micro) begin ir = a ^ 4'hA; uc = {1'b1, a}; end
    else       begin ir = a;        uc = {1'b0, a ^ 4'h6}; end
  endtask

  // One cycle: set ports at negedge, check reads (old values), then clock.
  task automatic step(input string tag, input bit wm, input logic [AW-1:0] w,
                      input bit am, input logic [AW-1:0] a,
                      input bit bm, input logic [AW-1:0] b,
                      input bit we, input logic [DW-1:0] d);
    @(negedge clk);
    drive(wm, w, ir_wr_addr, uc_wr_field);
    drive(am, a, ir_rda_addr, uc_rda_field);
    drive(bm, b, ir_rdb_addr, uc_rdb_field);
    wr_en = we;
    wr_data = d;
    #1;
    check({tag, " port A"}, rda_data, model[a]);
    check({tag, " port B"}, rdb_data, model[b]);
    @(posedge clk);
    if (we && w != 0) model[w] = d;
  endtask

  task automatic read_all(input string tag);
    for (int i = 0; i < NR; i++)
      step(tag, 1'b1, 4'(i), 1'b1, 4'(i), 1'b0, 4'(NR-1-i), 1'b0, '0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    wr_en = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < NR; i++) model[i] = '0;
  endtask

  task automatic t_reset();
    read_all("R8 reset clears");
  endtask

  task automatic t_fill();
    for (int i = 1; i < NR; i++)
      step("R3 fill", 1'b1, 4'(i), 1'b0, 4'(i), 1'b1, 4'(i), 1'b1, DW'(16'h1100 + i * 16'h0101));
    read_all("R1 R3 readback");
  endtask

  task automatic t_source_select();
    // R2: instruction-derived destination, decoy in micro field
    step("R2 instr dest", 1'b0, 4'd5, 1'b1, 4'd5, 1'b0, 4'd5, 1'b1, 16'hA5A5);
    step("R2 instr dest read", 1'b0, 4'd7, 1'b0, 4'd5, 1'b1, 4'd5, 1'b0, '0);
    // R2: micro destination, decoy in instruction field
    step("R2 micro dest", 1'b1, 4'd9, 1'b0, 4'd9, 1'b1, 4'd9, 1'b1, 16'h3C3C);
    step("R2 micro dest read", 1'b1, 4'd1, 1'b1, 4'd9, 1'b0, 4'd9, 1'b0, '0);
    read_all("R2 no stray writes");
  endtask

  task automatic t_reg0();
    step("R6 write r0 micro", 1'b1, 4'd0, 1'b1, 4'd0, 1'b0, 4'd0, 1'b1, 16'hFFFF);
    step("R6 write r0 instr", 1'b0, 4'd0, 1'b0, 4'd0, 1'b1, 4'd0, 1'b1, 16'hBEEF);
    step("R5 r0 reads zero", 1'b0, 4'd0, 1'b1, 4'd0, 1'b0, 4'd0, 1'b0, '0);
    read_all("R6 r0 write touched nothing");
  endtask

  task automatic t_we_low();
    for (int i = 1; i < NR; i++)
      step("R4 enable low", 1'b1, 4'(i), 1'b0, 4'(i), 1'b1, 4'(i), 1'b0, 16'hDEAD);
    read_all("R4 unchanged");
  endtask

  task automatic t_read_during_write();
    // same-cycle read shows old word (checked inside step), next cycle shows new
    step("R7 same cycle", 1'b1, 4'd12, 1'b1, 4'd12, 1'b0, 4'd12, 1'b1, 16'h7E57);
    step("R7 next cycle", 1'b1, 4'd12, 1'b0, 4'd12, 1'b1, 4'd12, 1'b1, 16'h0F0F);
    step("R7 after second", 1'b1, 4'd3, 1'b1, 4'd12, 1'b1, 4'd12, 1'b0, '0);
  endtask

  task automatic t_random();
    for (int n = 0; n < 400; n++)
      step("R9 random", 1'($urandom), 4'($urandom), 1'($urandom), 4'($urandom),
           1'($urandom), 4'($urandom), 1'($urandom), DW'($urandom));
    read_all("R9 random final");
  endtask

  initial begin
    for (int i = 0; i < NR; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_fill();
    t_source_select();
    t_reg0();
    t_we_low();
    t_read_during_write();
    t_random();
    do_reset();
    t_reset();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog (all requirements) actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule